// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer

This block takes single-byte read and write requests that carry a flat address. It plays each one out as a strobe-by-strobe cycle on an asynchronous DRAM. The row and column halves of the address take turns on one shared address bus. One of two row strobes selects the bank. The write strobe is active low. The data bus is split into an output value, an output enable and an input value, so that the tri-state buffer can sit at the chip pad.

A 4-bit configuration input gives the address-bit count n. This count sets the width of the row and column fields and the bit position where the bank select begins. Each step of a cycle holds for `STEP_CYC` clock cycles, so that strobe-to-strobe and access times can be met at any clock rate. After reset the block first runs one refresh cycle, which pulls both row strobes low. Only after that does it accept work.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request whose valid is held while the block is busy waits, and it is taken on the first idle cycle. Completion is a one-cycle `rsp_valid` pulse. This pulse cannot be back-pressured. Read data on `rsp_rdata` is valid with the pulse and holds until the next read completes.

Top module: `rascas_seq`

## Requirements
- R1: With n = `cfg_abits` (binary, values 0 treated as 1 and values above 12 treated as 12), the row presented while the row strobe falls is (addr >> n) & (2^n - 1), and the column presented while the column strobe falls is addr & (2^n - 1).
- R2: An access uses `mem_ras_n[1]` when any address bit at position 2n or above is set, and `mem_ras_n[0]` otherwise.
- R3: A write asserts its strobes in this order: data driven (`mem_dq_oe`=1), WE low, row, bank RAS low, column, CAS low, RAS high, CAS high, data released, WE high. CAS falls only while a RAS is low, RAS returns high before CAS, and the read-back value equals the written byte.
- R4: A read first holds WE high, drives 0x00 for one step, then floats the bus before the row strobe falls, and it samples the bus at the end of the CAS step. A read from a bank that does not answer returns 0x00.
- R5: During reset all strobes are high (`mem_ras_n`=2'b11, `mem_cas_n`=1, `mem_we_n`=1), `mem_dq_oe` is 0 and `req_ready` is 0.
- R6: After reset, both RAS lines are low together for exactly `STEP_CYC` cycles, with CAS and WE high, before `req_ready` first rises.
- R7: Every step lasts `STEP_CYC` cycles. `rsp_valid` rises 10*`STEP_CYC` cycles after the edge that accepts a write, and 9*`STEP_CYC` cycles after the edge that accepts a read.
- R8: A request is taken only on an edge where `req_valid` and `req_ready` are both high. Requests presented while busy leave memory untouched. `rsp_valid` is a single-cycle pulse, and `rsp_rdata` holds after it.
- R9: `mem_dq_oe` is high only while a write drives data or during the zero phase of a read. It is always low when CAS falls during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_abits | input | 4 | Address-bit count n per row/column field |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flat byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Last read byte, valid with rsp_valid |
| mem_addr | output | MA_W | Multiplexed row/column address |
| mem_ras_n | output | 2 | Row strobes, one per bank, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | DW | Data bus input value |

## Verification
On every cycle the assertions check the following strobe relations:
- CAS never falls without a RAS low.
- The data bus is driven whenever CAS is low with WE low, and it is free when CAS falls during a read.
- The address holds while CAS is low.
- A refresh never shows CAS or WE low.
- Readiness never comes before the boot refresh.
- The completion pulse lasts one cycle.
- The step counter stays in range.

Other behaviours only the bench can show:
- The arithmetic of the row, column and bank split.
- The exact ordering of the write and read sequences, including the zero-drive phase.
- The latency figures.
- That a request held while busy never reaches memory.
- That an absent bank reads back zero.

The bench shows these with a bus-keeping memory model and address sweeps at several values of n.

// File: rtl/rascas_pkg.sv
package rascas_pkg;

  typedef enum logic [4:0] {
    ST_BOOT, ST_F_RAS, ST_F_REL, ST_IDLE,
    ST_W_DATA, ST_W_WE, ST_W_ROW, ST_W_RAS, ST_W_COL,
    ST_W_CAS, ST_W_RRAS, ST_W_RCAS, ST_W_RDAT, ST_W_WEOFF,
    ST_R_WEOFF, ST_R_ZERO, ST_R_FLOAT, ST_R_ROW, ST_R_RAS,
    ST_R_COL, ST_R_CAS, ST_R_RRAS, ST_R_RCAS
  } seq_st_e;

  // successor of each timed step; the last step of each cycle returns to idle
  function automatic seq_st_e next_step(seq_st_e s);
    case (s)
      ST_BOOT:    return ST_F_RAS;
      ST_F_RAS:   return ST_F_REL;
      ST_W_DATA:  return ST_W_WE;
      ST_W_WE:    return ST_W_ROW;
      ST_W_ROW:   return ST_W_RAS;
      ST_W_RAS:   return ST_W_COL;
      ST_W_COL:   return ST_W_CAS;
      ST_W_CAS:   return ST_W_RRAS;
      ST_W_RRAS:  return ST_W_RCAS;
      ST_W_RCAS:  return ST_W_RDAT;
      ST_W_RDAT:  return ST_W_WEOFF;
      ST_R_WEOFF: return ST_R_ZERO;
      ST_R_ZERO:  return ST_R_FLOAT;
      ST_R_FLOAT: return ST_R_ROW;
      ST_R_ROW:   return ST_R_RAS;
      ST_R_RAS:   return ST_R_COL;
      ST_R_COL:   return ST_R_CAS;
      ST_R_CAS:   return ST_R_RRAS;
      ST_R_RRAS:  return ST_R_RCAS;
      default:    return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rascas_addr_split.sv
module rascas_addr_split #(
  parameter int ADDR_W = 26,
  parameter int MA_W   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        abits,
  output logic [MA_W-1:0]   row,
  output logic [MA_W-1:0]   col,
  output logic              bank
);
  logic [3:0]        n;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] upper;

  always_comb begin
    if (abits == 4'd0)              n = 4'd1;
    else if (int'(abits) > MA_W)    n = 4'(MA_W);
    else                            n = abits;
    mask    = (ADDR_W'(1) << n) - ADDR_W'(1);
    shifted = addr >> n;
    upper   = addr >> {n, 1'b0};
    row     = MA_W'(shifted & mask);
    col     = MA_W'(addr & mask);
    bank    = |upper;
  end
endmodule

// File: rtl/rascas_step_timer.sv
module rascas_step_timer #(
  parameter int STEP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R7
endmodule

// File: rtl/rascas_seq.sv
module rascas_seq
  import rascas_pkg::*;
#(
  parameter int ADDR_W   = 26,
  parameter int MA_W     = 12,
  parameter int DW       = 8,
  parameter int STEP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_abits,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [MA_W-1:0]   mem_addr,
  output logic [1:0]        mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in
);
  localparam int NBANK = 2;

  seq_st_e         state;
  logic            step_done, run;
  logic            refreshed;
  logic [MA_W-1:0] sp_row, sp_col, lat_row, lat_col;
  logic            sp_bank, lat_bank;
  logic [DW-1:0]   lat_wdata;
  logic            ras_all, ras_one, cas_low, we_low, use_col;

  rascas_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W)) u_split (
    .addr(req_addr), .abits(cfg_abits), .row(sp_row), .col(sp_col), .bank(sp_bank)
  );

  assign run = !(state inside {ST_BOOT, ST_IDLE});

  rascas_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .done(step_done)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      rsp_valid <= 1'b0;
      refreshed <= 1'b0;
      rsp_rdata <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_bank  <= 1'b0;
      lat_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_BOOT: state <= ST_F_RAS;
        ST_IDLE: if (req_valid) begin
          lat_row   <= sp_row;
          lat_col   <= sp_col;
          lat_bank  <= sp_bank;
          lat_wdata <= req_wdata;
          state     <= req_write ? ST_W_DATA : ST_R_WEOFF;
        end
        default: if (step_done) begin
          state <= next_step(state);
          if (state == ST_F_REL) refreshed <= 1'b1;
          if (state inside {ST_W_WEOFF, ST_R_RCAS}) rsp_valid <= 1'b1;
          if (state == ST_R_CAS) rsp_rdata <= mem_dq_in;
        end
      endcase
    end
  end

  // strobe decode per step
  always_comb begin
    ras_all   = (state == ST_F_RAS);
    ras_one   = state inside {ST_W_RAS, ST_W_COL, ST_W_CAS, ST_R_RAS, ST_R_COL, ST_R_CAS};
    cas_low   = state inside {ST_W_CAS, ST_W_RRAS, ST_R_CAS, ST_R_RRAS};
    we_low    = state inside {ST_W_WE, ST_W_ROW, ST_W_RAS, ST_W_COL, ST_W_CAS,
                              ST_W_RRAS, ST_W_RCAS, ST_W_RDAT};
    use_col   = state inside {ST_W_COL, ST_W_CAS, ST_W_RRAS, ST_W_RCAS, ST_W_RDAT,
                              ST_W_WEOFF, ST_R_COL, ST_R_CAS, ST_R_RRAS, ST_R_RCAS};
    mem_dq_oe = state inside {ST_W_DATA, ST_W_WE, ST_W_ROW, ST_W_RAS, ST_W_COL,
                              ST_W_CAS, ST_W_RRAS, ST_W_RCAS, ST_R_ZERO};
    mem_dq_out = (state == ST_R_ZERO) ? '0 : lat_wdata;
    mem_cas_n  = !cas_low;
    mem_we_n   = !we_low;
    mem_addr   = ras_all ? '0 : (use_col ? lat_col : lat_row);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    assign mem_ras_n[b] = !(ras_all || (ras_one && (lat_bank == 1'(b))));
  end

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> (mem_ras_n != 2'b11)); // R3
  AST_WRITE_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cas_n && !mem_we_n) |-> mem_dq_oe); // R3
  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cas_n) && mem_we_n) |-> !mem_dq_oe); // R9
  AST_ADDR_HELD_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> $stable(mem_addr)); // R1
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ras_n == 2'b00) |-> (mem_cas_n && mem_we_n)); // R6
  AST_READY_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> refreshed); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/rascas_seq_test.sv
`timescale 1ns/1ps
module rascas_seq_test;
  localparam int S  = 3;
  localparam int AW = 26;
  localparam int MW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [3:0]    cfg_abits = 4'd2;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          rsp_valid;
  logic [7:0]    rsp_rdata;
  logic [MW-1:0] mem_addr;
  logic [1:0]    mem_ras_n;
  logic          mem_cas_n, mem_we_n, mem_dq_oe;
  logic [7:0]    mem_dq_out, mem_dq_in;

  rascas_seq #(.ADDR_W(AW), .MA_W(MW), .DW(8), .STEP_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_abits(cfg_abits),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- DRAM model with a bus keeper ----
  logic [7:0]    mdl [longint];
  bit            b1_present = 1'b1;
  logic [MW-1:0] lrow0 = '0, lrow1 = '0, obs_row = '0, obs_col = '0;
  int            obs_bank = 0;
  logic [7:0]    mdata = '0, keeper = '0;
  logic          mdrive;

  always @(negedge mem_ras_n[0]) lrow0 = mem_addr;
  always @(negedge mem_ras_n[1]) lrow1 = mem_addr;
  always @(negedge mem_cas_n) begin
    longint key;
    obs_bank = mem_ras_n[0] ? 1 : 0;
    obs_row  = (obs_bank == 1) ? lrow1 : lrow0;
    obs_col  = mem_addr;
    key = longint'(obs_bank) * 64'h100_0000 + longint'(obs_row) * 4096 + longint'(obs_col);
    if (!mem_we_n) begin
      if (obs_bank == 0 || b1_present) mdl[key] = mem_dq_out;
    end else begin
      mdata = mdl.exists(key) ? mdl[key] : 8'h00;
    end
  end
  assign mdrive = !mem_cas_n && mem_we_n && (!mem_ras_n[0] || (!mem_ras_n[1] && b1_present));
  assign mem_dq_in = mem_dq_oe ? mem_dq_out : (mdrive ? mdata : keeper);
  always @(posedge clk) keeper <= mem_dq_in;

  // ---- pin-order monitor ----
  logic [1:0] pras = 2'b11;
  logic       pcas = 1'b1, pwe = 1'b1;
  bit         seen_zero = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (pcas && !mem_cas_n) begin
      chk(mem_ras_n != 2'b11, "R3", "CAS fell with no RAS", longint'(mem_ras_n), 0);
      if (!mem_we_n) chk(mem_dq_oe, "R3", "write CAS with bus not driven", 0, 1);
      else           chk(!mem_dq_oe, "R9", "read CAS with bus driven", 1, 0);
    end
    if (pras != 2'b11 && pras != 2'b00 && mem_ras_n == 2'b11)
      chk(!mem_cas_n, "R3", "RAS not released before CAS", longint'(mem_cas_n), 0);
    if (!pwe && mem_we_n)
      chk(!mem_dq_oe && mem_cas_n, "R3", "WE rose while bus or CAS active", longint'(mem_dq_oe), 0);
    if (pras == 2'b11 && mem_ras_n != 2'b11 && mem_ras_n != 2'b00 && mem_we_n)
      chk(seen_zero, "R4", "read RAS without zero-drive phase", 0, 1);
    if (mem_dq_oe && mem_we_n && mem_ras_n == 2'b11 && mem_dq_out == 8'h00) seen_zero = 1'b1;
    if (!pcas && mem_cas_n) seen_zero = 1'b0;
    pras = mem_ras_n; pcas = mem_cas_n; pwe = mem_we_n;
  end

  // ---- helpers ----
  function automatic int clampn(int c);
    return (c == 0) ? 1 : (c > MW ? MW : c);
  endfunction

  function automatic logic [7:0] pat(longint a, int n);
    return 8'((a * 29) + (n * 53) + 7);
  endfunction

  task automatic access(bit wr, longint a, logic [7:0] d, bit junk, output logic [7:0] rd);
    int lat;
    int n;
    n = clampn(int'(cfg_abits));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = junk;
    if (junk) begin req_write = 1'b1; req_addr = AW'(6); req_wdata = 8'h99; end
    lat = 0;
    while (!rsp_valid && lat < 1000) begin @(negedge clk); lat++; end
    req_valid = 1'b0;
    rd = rsp_rdata;
    chk(lat == (wr ? 10 : 9) * S, "R7", "completion latency", lat, (wr ? 10 : 9) * S);
    chk(obs_row == MW'((a >> n) & ((64'd1 << n) - 1)), "R1", "row field",
        longint'(obs_row), (a >> n) & ((64'd1 << n) - 1));
    chk(obs_col == MW'(a & ((64'd1 << n) - 1)), "R1", "column field",
        longint'(obs_col), a & ((64'd1 << n) - 1));
    chk(obs_bank == (((a >> (2 * n)) != 0) ? 1 : 0), "R2", "bank select",
        obs_bank, ((a >> (2 * n)) != 0) ? 1 : 0);
    @(negedge clk);
    chk(!rsp_valid, "R8", "completion pulse longer than one cycle", 1, 0);
    if (!wr) chk(rsp_rdata == rd, "R8", "read data not held", longint'(rsp_rdata), longint'(rd));
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int cnt;
    repeat (3) @(negedge clk);
    chk(mem_ras_n == 2'b11 && mem_cas_n && mem_we_n, "R5", "strobes in reset",
        longint'({mem_ras_n, mem_cas_n, mem_we_n}), 4'hf);
    chk(!mem_dq_oe && !req_ready, "R5", "oe/ready in reset", longint'({mem_dq_oe, req_ready}), 0);
    rst_n = 1'b1;
    cnt = 0;
    while (!req_ready && cnt < 1000) begin
      @(negedge clk);
      if (mem_ras_n == 2'b00) cnt++;
    end
    chk(cnt == S, "R6", "boot refresh cycles with both RAS low", cnt, S);

    // sweeps over small configurations
    for (int n = 1; n <= 3; n++) begin
      cfg_abits = 4'(n);
      for (longint a = 0; a < (64'd1 << (2 * n + 1)); a++) access(1'b1, a, pat(a, n), 1'b0, rd);
      for (longint a = 0; a < (64'd1 << (2 * n + 1)); a++) begin
        access(1'b0, a, 8'h00, 1'b0, rd);
        chk(rd == pat(a, n), "R3", "read-back of written byte", longint'(rd), longint'(pat(a, n)));
      end
    end

    // full-width corners
    cfg_abits = 4'd12;
    access(1'b1, 64'hFF_FFFF, 8'h3C, 1'b0, rd);
    access(1'b1, 64'h100_0000, 8'hC3, 1'b0, rd);
    access(1'b0, 64'hFF_FFFF, 8'h00, 1'b0, rd);
    chk(rd == 8'h3C, "R2", "top of first bank", longint'(rd), 8'h3C);
    access(1'b0, 64'h100_0000, 8'h00, 1'b0, rd);
    chk(rd == 8'hC3, "R2", "base of second bank", longint'(rd), 8'hC3);
    cfg_abits = 4'd2;
    access(1'b0, 64'h200_0000, 8'h00, 1'b0, rd);   // only the top bit set: second bank
    cfg_abits = 4'd0;                              // treated as n=1
    access(1'b1, 5, 8'h5A, 1'b0, rd);
    cfg_abits = 4'd15;                             // treated as n=12
    access(1'b0, 64'h100_0000, 8'h00, 1'b0, rd);
    chk(rd == 8'hC3, "R1", "clamped address-bit count", longint'(rd), 8'hC3);

    // request held while busy must not be taken early
    cfg_abits = 4'd2;
    access(1'b1, 6, 8'h44, 1'b0, rd);
    access(1'b1, 3, 8'h22, 1'b1, rd);
    access(1'b0, 6, 8'h00, 1'b0, rd);
    chk(rd == 8'h44, "R8", "busy-time request reached memory", longint'(rd), 8'h44);
    access(1'b0, 3, 8'h00, 1'b0, rd);
    chk(rd == 8'h22, "R8", "accepted write", longint'(rd), 8'h22);

    // absent second bank reads zero
    b1_present = 1'b0;
    access(1'b1, 20, 8'hA5, 1'b0, rd);
    access(1'b0, 20, 8'h00, 1'b0, rd);
    chk(rd == 8'h00, "R4", "absent bank read", longint'(rd), 0);
    access(1'b0, 3, 8'h00, 1'b0, rd);
    chk(rd == 8'h22, "R4", "present bank after absent read", longint'(rd), 8'h22);

    @(negedge clk);
    chk(mem_ras_n == 2'b11 && mem_cas_n && mem_we_n && !mem_dq_oe && req_ready, "R9",
        "idle pins", longint'({mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe}), 5'b11110);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule